// File: doc/BRIEF.md
# Transactional Store Buffer

This block sits between a core and its private data cache and holds the stores the core makes inside a transaction, one 32-bit word per entry. It has two policies, chosen when a transaction begins. In lazy mode the words stay in the buffer until commit, which writes them all to the cache, or until abort, which throws them away without touching the cache. In eager mode the words go to the cache while the transaction runs. They go either at once or only while the occupancy is at or above a threshold. Words still waiting when an eager transaction aborts are still written to the cache, in the background.

Core loads read the buffer and get any word it holds. Each newly buffered word probes the cache for its line. A miss raises a one-cycle, non-exclusive prefetch request, which needs no handshake. When every entry is in use, a store to a word that is not already buffered goes straight to the cache write port. The core is held back only while that port is not ready. Stores made outside a transaction pass straight to the cache, but only once the buffer has emptied.

Top module: `txn_store_buffer`

## Requirements
- R1: After synchronous active-low reset the buffer is empty, the state is idle, and cwr_valid_o, ld_hit_o, pf_valid_o and commit_done_o are all 0.
- R2: In a lazy transaction that has free entries, no store reaches the cache write port before commit.
- R3: A load address whose word is buffered gives ld_hit_o=1 and the data of the most recent store to that word, in the same cycle. A store to a word that is already buffered overwrites that entry in place, so the word is written to the cache once.
- R4: After commit, the entries are written to the cache in the order they were captured, one per cycle while cwr_ready_i=1. commit_done_o then pulses for one cycle once the buffer is empty, and the block returns to idle.
- R5: A lazy abort empties the buffer in one cycle with no cache write, and no commit_done_o pulse follows.
- R6: When all DEPTH entries are in use, a transactional store to a word that is not buffered is presented on the cache write port. st_ready_o=0 only in that case and only while cwr_ready_i=0. A store that merges never stalls.
- R7: In an eager transaction with immediate draining, a captured word is presented to the cache in the cycle after it is captured.
- R8: In an eager transaction with deferred draining, entries are written only while occupancy is at or above THRESH = floor(DEPTH*THRESH_PCT/100), which is 25 for the defaults and 6 for DEPTH=8.
- R9: On an eager abort, every pending word is still written to the cache, in capture order, and no commit_done_o pulse is raised.
- R10: A store that allocates a new entry while probe_hit_i=0 for its line (st_addr_i >> LINE_W) raises pf_valid_o for one cycle, in the next cycle, with that line on pf_line_o. Merging stores and direct stores raise no prefetch.
- R11: The mode is latched at tx_begin_i, and later changes on the mode pins do not affect the running transaction. A commit outside a transaction is ignored.
- R12: If a store hits the word at the head of the buffer in the same cycle the cache accepts that head entry, the new data takes a fresh entry. Both values are then written, the old value first.
- R13: Outside a transaction, a store goes straight to the cache when the block is idle and empty. Otherwise it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_eager_i | input | 1 | 1 selects eager mode, latched at begin |
| drain_defer_i | input | 1 | 1 selects threshold-deferred draining in eager mode, latched at begin |
| tx_begin_i | input | 1 | Start a transaction (honoured only when idle) |
| tx_commit_i | input | 1 | Commit the running transaction |
| tx_abort_i | input | 1 | Abort the running transaction (wins over commit) |
| st_valid_i | input | 1 | Core store request |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Store accepted this cycle |
| ld_addr_i | input | ADDR_W | Load word address for forwarding |
| ld_hit_o | output | 1 | Load word is buffered |
| ld_data_o | output | DATA_W | Forwarded data |
| cwr_valid_o | output | 1 | Cache write request |
| cwr_ready_i | input | 1 | Cache accepts the write |
| cwr_addr_o | output | ADDR_W | Cache write word address |
| cwr_data_o | output | DATA_W | Cache write data |
| probe_line_o | output | ADDR_W-LINE_W | Line address of the current store, for the presence probe |
| probe_hit_i | input | 1 | Line is present in the cache |
| pf_valid_o | output | 1 | Non-exclusive prefetch request |
| pf_line_o | output | ADDR_W-LINE_W | Prefetch line address |
| commit_done_o | output | 1 | One-cycle pulse when a commit flush has finished |

## Verification
Storing to a word and draining that same word to the cache can happen in the same cycle, when the store hits the head entry as the cache accepts it. The bench sets this up in an eager, immediate-drain transaction. It holds the cache port off until one word sits at the head. It then raises cwr_ready_i together with a second store to the same word. The check is that both values reach the cache, the old one first. A second overlap, a direct store past a full buffer while the cache port is busy, is judged from st_ready_o and the cache port in the same cycle.

// File: rtl/tsb_pkg.sv
// Shared types for the transactional store buffer.
package tsb_pkg;
    // Controller state: idle, transaction open, commit flush, eager-abort drain.
    typedef enum logic [1:0] {
        TSB_IDLE   = 2'd0,
        TSB_TX     = 2'd1,
        TSB_FLUSH  = 2'd2,
        TSB_LINGER = 2'd3
    } tsb_state_e;
endpackage

// File: rtl/tsb_entry_store.sv
// Word-entry storage kept as a circular queue in capture order.
// Assumes: at most one valid entry per word address (the top merges repeats),
// alloc and merge are never asserted together, and the top never allocates
// into a full queue unless it pops in the same cycle.
module tsb_entry_store #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              alloc_i,
    input  logic              merge_i,
    input  logic [IDX_W-1:0]  merge_idx_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              st_hit_o,
    output logic [IDX_W-1:0]  st_idx_o,
    output logic              ld_hit_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              head_valid_o,
    output logic [IDX_W-1:0]  head_idx_o,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o
);
    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [IDX_W-1:0]  head_q, tail_q, ld_idx;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  st_match, ld_match;

    // Advance a queue pointer with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-entry address comparators for the store and load ports.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign st_match[g] = vld_q[g] && (addr_q[g] == wr_addr_i);
        assign ld_match[g] = vld_q[g] && (addr_q[g] == ld_addr_i);
    end

    // Encode the single matching entry for each port.
    always_comb begin
        st_hit_o = 1'b0;
        st_idx_o = '0;
        ld_hit_o = 1'b0;
        ld_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_match[i]) begin
                st_hit_o = 1'b1;
                st_idx_o = IDX_W'(i);
            end
            if (ld_match[i]) begin
                ld_hit_o = 1'b1;
                ld_idx   = IDX_W'(i);
            end
        end
    end

    assign ld_data_o    = data_q[ld_idx];
    assign head_valid_o = vld_q[head_q];
    assign head_idx_o   = head_q;
    assign head_addr_o  = addr_q[head_q];
    assign head_data_o  = data_q[head_q];
    assign count_o      = cnt_q;
    assign full_o       = (cnt_q == CNT_W'(DEPTH));

    // Valid bits, pointers and occupancy; a pop and an alloc may share a slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop_i) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= bump(head_q);
            end
            if (alloc_i) begin
                vld_q[tail_q] <= 1'b1;
                tail_q        <= bump(tail_q);
            end
            cnt_q <= cnt_q + CNT_W'(alloc_i) - CNT_W'(pop_i);
        end
    end

    // Entry payload: fill on allocation, overwrite data on merge.
    always_ff @(posedge clk) begin
        if (alloc_i) begin
            addr_q[tail_q] <= wr_addr_i;
            data_q[tail_q] <= wr_data_i;
        end else if (merge_i) begin
            data_q[merge_idx_i] <= wr_data_i;
        end
    end
endmodule

// File: rtl/tsb_ctrl.sv
// Transaction controller: latches the mode at begin, tracks the phase and
// decides when the queue may drain. Assumes count_i is the live occupancy.
module tsb_ctrl #(
    parameter int CNT_W  = 6,
    parameter int THRESH = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_begin_i,
    input  logic               tx_commit_i,
    input  logic               tx_abort_i,
    input  logic               eager_i,
    input  logic               defer_i,
    input  logic [CNT_W-1:0]   count_i,
    output tsb_pkg::tsb_state_e state_o,
    output logic               eager_o,
    output logic               clear_o,
    output logic               drain_en_o,
    output logic               done_o
);
    import tsb_pkg::*;

    tsb_state_e state_q;
    logic       eager_q, defer_q;
    logic       empty;

    assign empty = (count_i == '0);

    // Phase sequencing and mode capture at transaction start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TSB_IDLE;
            eager_q <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            case (state_q)
                TSB_IDLE: if (tx_begin_i) begin
                    state_q <= TSB_TX;
                    eager_q <= eager_i;
                    defer_q <= defer_i;
                end
                TSB_TX: begin
                    if (tx_abort_i)       state_q <= eager_q ? TSB_LINGER : TSB_IDLE;
                    else if (tx_commit_i) state_q <= TSB_FLUSH;
                end
                TSB_FLUSH:  if (empty) state_q <= TSB_IDLE;
                TSB_LINGER: if (empty) state_q <= TSB_IDLE;
                default:    state_q <= TSB_IDLE;
            endcase
        end
    end

    // Drain permission per phase and latched policy.
    always_comb begin
        case (state_q)
            TSB_TX:     drain_en_o = eager_q && (!defer_q || (count_i >= CNT_W'(THRESH)));
            TSB_FLUSH,
            TSB_LINGER: drain_en_o = 1'b1;
            default:    drain_en_o = 1'b0;
        endcase
    end

    assign clear_o = (state_q == TSB_TX) && tx_abort_i && !eager_q;
    assign done_o  = (state_q == TSB_FLUSH) && empty;
    assign state_o = state_q;
    assign eager_o = eager_q;
endmodule

// File: rtl/tsb_prefetch.sv
// Prefetch issuer: registers a one-cycle non-exclusive read request for the
// line of a newly buffered word that the cache probe reported absent.
module tsb_prefetch #(
    parameter int LINE_A_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [LINE_A_W-1:0] line_i,
    output logic                pf_valid_o,
    output logic [LINE_A_W-1:0] pf_line_o
);
    // Hold the request for exactly one cycle; no handshake is needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid_o <= 1'b0;
            pf_line_o  <= '0;
        end else begin
            pf_valid_o <= req_i;
            if (req_i) pf_line_o <= line_i;
        end
    end
endmodule

// File: rtl/txn_store_buffer.sv
// Transactional store buffer between a core and its private data cache.
// Routes each core store into the queue, onto the cache port or into a stall.
// Shares the single cache write port between direct stores (priority) and
// draining. Assumes word addresses and a cache port that holds no state.
module txn_store_buffer #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 32,
    parameter int LINE_W     = 4,
    parameter int THRESH_PCT = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_eager_i,
    input  logic                     drain_defer_i,
    input  logic                     tx_begin_i,
    input  logic                     tx_commit_i,
    input  logic                     tx_abort_i,
    input  logic                     st_valid_i,
    input  logic [ADDR_W-1:0]        st_addr_i,
    input  logic [DATA_W-1:0]        st_data_i,
    output logic                     st_ready_o,
    input  logic [ADDR_W-1:0]        ld_addr_i,
    output logic                     ld_hit_o,
    output logic [DATA_W-1:0]        ld_data_o,
    output logic                     cwr_valid_o,
    input  logic                     cwr_ready_i,
    output logic [ADDR_W-1:0]        cwr_addr_o,
    output logic [DATA_W-1:0]        cwr_data_o,
    output logic [ADDR_W-LINE_W-1:0] probe_line_o,
    input  logic                     probe_hit_i,
    output logic                     pf_valid_o,
    output logic [ADDR_W-LINE_W-1:0] pf_line_o,
    output logic                     commit_done_o
);
    import tsb_pkg::*;

    localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int LINE_A_W   = ADDR_W - LINE_W;
    localparam int THRESH_RAW = (DEPTH * THRESH_PCT) / 100;
    localparam int THRESH     = (THRESH_RAW < 1) ? 1 : THRESH_RAW;

    tsb_state_e        state;
    logic              eager_q, clear, drain_en;
    logic              st_hit, head_valid, full;
    logic [IDX_W-1:0]  st_idx, head_idx;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  cnt;
    logic              in_tx, can_buf, go_direct, direct_req;
    logic              drain_sel, pop, collide, buf_fire, alloc, merge;

    // Store routing: buffer it, send it past a full queue, or stall it.
    always_comb begin
        in_tx      = (state == TSB_TX);
        can_buf    = in_tx && (st_hit || !full);
        go_direct  = (in_tx && !st_hit && full) || ((state == TSB_IDLE) && (cnt == '0));
        direct_req = st_valid_i && go_direct;
        drain_sel  = drain_en && head_valid && !direct_req;
        pop        = drain_sel && cwr_ready_i;
        collide    = st_hit && (st_idx == head_idx) && pop;
        buf_fire   = st_valid_i && can_buf;
        alloc      = buf_fire && (!st_hit || collide);
        merge      = buf_fire && st_hit && !collide;
        st_ready_o = can_buf || (go_direct && cwr_ready_i);
    end

    // Cache write port mux: a direct store wins over draining.
    always_comb begin
        cwr_valid_o = direct_req || drain_sel;
        cwr_addr_o  = direct_req ? st_addr_i : head_addr;
        cwr_data_o  = direct_req ? st_data_i : head_data;
    end

    assign probe_line_o = st_addr_i[ADDR_W-1:LINE_W];

    tsb_entry_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(clear),
        .alloc_i(alloc), .merge_i(merge), .merge_idx_i(st_idx), .pop_i(pop),
        .wr_addr_i(st_addr_i), .wr_data_i(st_data_i), .ld_addr_i(ld_addr_i),
        .st_hit_o(st_hit), .st_idx_o(st_idx), .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o),
        .head_valid_o(head_valid), .head_idx_o(head_idx), .head_addr_o(head_addr),
        .head_data_o(head_data), .count_o(cnt), .full_o(full)
    );

    tsb_ctrl #(.CNT_W(CNT_W), .THRESH(THRESH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .tx_commit_i(tx_commit_i),
        .tx_abort_i(tx_abort_i), .eager_i(mode_eager_i), .defer_i(drain_defer_i),
        .count_i(cnt), .state_o(state), .eager_o(eager_q), .clear_o(clear),
        .drain_en_o(drain_en), .done_o(commit_done_o)
    );

    tsb_prefetch #(.LINE_A_W(LINE_A_W)) u_pf (
        .clk(clk), .rst_n(rst_n), .req_i(alloc && !probe_hit_i),
        .line_i(st_addr_i[ADDR_W-1:LINE_W]), .pf_valid_o(pf_valid_o), .pf_line_o(pf_line_o)
    );
endmodule

// File: rtl/tsb_chk.sv
// Property checker for the transactional store buffer, bound to the top.
module tsb_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input tsb_pkg::tsb_state_e state,
    input logic                eager_q,
    input logic [CNT_W-1:0]    cnt,
    input logic                full,
    input logic                st_valid_i,
    input logic                st_ready_o,
    input logic                cwr_valid_o,
    input logic                cwr_ready_i,
    input logic                commit_done_o,
    input logic                tx_abort_i,
    input logic                pf_valid_o
);
    import tsb_pkg::*;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_lazy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TSB_TX && !eager_q && !full) |-> !cwr_valid_o);

    p_done_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done_o |=> (state == TSB_IDLE && !commit_done_o));

    p_lazy_abort_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort_i && state == TSB_TX && !eager_q) |=> (cnt == '0 && state == TSB_IDLE));

    p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TSB_TX && st_valid_i && !st_ready_o) |-> (full && !cwr_ready_i));

    p_eager_abort_linger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort_i && state == TSB_TX && eager_q) |=> (state == TSB_LINGER));

    p_pf_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> $past(st_valid_i && st_ready_o && state == TSB_TX));
endmodule

bind txn_store_buffer tsb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .eager_q(eager_q), .cnt(cnt), .full(full),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .cwr_valid_o(cwr_valid_o),
    .cwr_ready_i(cwr_ready_i), .commit_done_o(commit_done_o), .tx_abort_i(tx_abort_i),
    .pf_valid_o(pf_valid_o)
);

// File: tb/tb_txn_store_buffer.sv
module tb_txn_store_buffer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_eager = 1'b0, drain_defer = 1'b0;
    logic tx_begin = 1'b0, tx_commit = 1'b0, tx_abort = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready_o, ld_hit_o, cwr_valid_o, pf_valid_o, commit_done_o;
    logic cwr_ready = 1'b1;
    logic [DW-1:0] ld_data_o, cwr_data_o;
    logic [AW-1:0] cwr_addr_o;
    logic [AW-LW-1:0] probe_line_o, pf_line_o;
    logic probe_hit;

    // Cache model: even line numbers are present.
    assign probe_hit = ~probe_line_o[0];

    txn_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .LINE_W(LW), .THRESH_PCT(80)) dut (
        .clk(clk), .rst_n(rst_n), .mode_eager_i(mode_eager), .drain_defer_i(drain_defer),
        .tx_begin_i(tx_begin), .tx_commit_i(tx_commit), .tx_abort_i(tx_abort),
        .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready_o),
        .ld_addr_i(ld_addr), .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o),
        .cwr_valid_o(cwr_valid_o), .cwr_ready_i(cwr_ready), .cwr_addr_o(cwr_addr_o),
        .cwr_data_o(cwr_data_o), .probe_line_o(probe_line_o), .probe_hit_i(probe_hit),
        .pf_valid_o(pf_valid_o), .pf_line_o(pf_line_o), .commit_done_o(commit_done_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] wa [128];
    logic [31:0] wd [128];
    int wn = 0, done_n = 0, pf_n = 0;
    logic [AW-LW-1:0] pf_last = '0;

    // Monitor just before each rising edge: cache writes, done pulses, prefetches.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (cwr_valid_o && cwr_ready) begin
                if (wn < 128) begin
                    wa[wn] = cwr_addr_o;
                    wd[wn] = cwr_data_o;
                end
                wn++;
            end
            if (commit_done_o) done_n++;
            if (pf_valid_o) begin
                pf_n++;
                pf_last = pf_line_o;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_tx(input logic eager, input logic defer);
        @(negedge clk);
        mode_eager = eager;
        drain_defer = defer;
        tx_begin = 1'b1;
        @(posedge clk);
        #1;
        tx_begin = 1'b0;
        mode_eager = ~eager;  // R11: mode pins move, latched mode must not
        drain_defer = ~defer;
    endtask

    task automatic do_commit();
        @(negedge clk);
        tx_commit = 1'b1;
        @(posedge clk);
        #1;
        tx_commit = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk);
        tx_abort = 1'b1;
        @(posedge clk);
        #1;
        tx_abort = 1'b0;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = a;
        st_data = d;
        #1;
        while (!st_ready_o) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic load_chk(input logic [31:0] a, input bit exp_hit, input logic [31:0] exp_d, input string tag);
        @(negedge clk);
        ld_addr = a;
        #1;
        check(ld_hit_o == exp_hit, {tag, " load hit"}, 64'(ld_hit_o), 64'(exp_hit));
        if (exp_hit) check(ld_data_o == exp_d, {tag, " load data"}, 64'(ld_data_o), 64'(exp_d));
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Stimulus table: {is_load, word addr, data, expected hit}.
    localparam int NV = 9;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 8'h10, 32'h0000_00A1, 1'b0},
        {1'b0, 8'h11, 32'h0000_00A2, 1'b0},
        {1'b0, 8'h25, 32'h0000_00A3, 1'b0},
        {1'b1, 8'h10, 32'h0000_00A1, 1'b1},
        {1'b1, 8'h12, 32'h0000_0000, 1'b0},
        {1'b0, 8'h10, 32'h0000_00B1, 1'b0},
        {1'b1, 8'h10, 32'h0000_00B1, 1'b1},
        {1'b1, 8'h25, 32'h0000_00A3, 1'b1},
        {1'b1, 8'h11, 32'h0000_00A2, 1'b1}
    };

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        report();
        $finish;
    end

    initial begin
        int base, dn, pn;
        // R1: reset state
        wait_cyc(3);
        #1;
        check(cwr_valid_o == 1'b0, "R1 cwr_valid", 64'(cwr_valid_o), 0);
        check(ld_hit_o == 1'b0, "R1 ld_hit", 64'(ld_hit_o), 0);
        check(pf_valid_o == 1'b0, "R1 pf_valid", 64'(pf_valid_o), 0);
        check(commit_done_o == 1'b0, "R1 commit_done", 64'(commit_done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 R3 R10 R11: lazy transaction walked from the table
        base = wn;
        begin_tx(1'b0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41]) load_chk(32'(VEC[i][40:33]), VEC[i][0], VEC[i][32:1], "R3");
            else do_store(32'(VEC[i][40:33]), VEC[i][32:1]);
        end
        wait_cyc(2);
        check(wn == base, "R2 R11 no write in lazy tx", 64'(wn - base), 0);
        check(pf_n == 2, "R10 prefetch count", 64'(pf_n), 2);
        check(pf_last == 28'h1, "R10 prefetch line", 64'(pf_last), 1);

        // R4: commit flush order and done pulse
        do_commit();
        wait_cyc(8);
        check(wn == base + 3, "R4 flush count", 64'(wn - base), 3);
        check(wa[base] == 32'h10 && wd[base] == 32'hB1, "R4 R3 first write", {wa[base], wd[base]}, {32'h10, 32'hB1});
        check(wa[base+1] == 32'h11 && wd[base+1] == 32'hA2, "R4 second write", {wa[base+1], wd[base+1]}, {32'h11, 32'hA2});
        check(wa[base+2] == 32'h25 && wd[base+2] == 32'hA3, "R4 third write", {wa[base+2], wd[base+2]}, {32'h25, 32'hA3});
        check(done_n == 1, "R4 done pulse", 64'(done_n), 1);
        load_chk(32'h10, 1'b0, 32'h0, "R4 empty after flush");
        do_commit();
        wait_cyc(3);
        check(done_n == 1, "R11 commit while idle ignored", 64'(done_n), 1);

        // R5: lazy abort discards
        base = wn;
        begin_tx(1'b0, 1'b0);
        do_store(32'h30, 32'h301);
        do_store(32'h31, 32'h311);
        do_abort();
        wait_cyc(4);
        check(wn == base, "R5 no write on abort", 64'(wn - base), 0);
        check(done_n == 1, "R5 no done on abort", 64'(done_n), 1);
        load_chk(32'h30, 1'b0, 32'h0, "R5 discarded");

        // R6: full buffer, direct store and stall, merge without stall
        base = wn;
        pn = pf_n;
        begin_tx(1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) do_store(32'h80 + 32'(i), 32'h800 + 32'(i));
        @(negedge clk);
        cwr_ready = 1'b0;
        st_valid = 1'b1;
        st_addr = 32'h90;
        st_data = 32'h9;
        #1;
        check(st_ready_o == 1'b0, "R6 stall when full and not ready", 64'(st_ready_o), 0);
        check(cwr_valid_o && cwr_addr_o == 32'h90, "R6 direct presented", 64'(cwr_addr_o), 64'h90);
        @(negedge clk);
        cwr_ready = 1'b1;
        #1;
        check(st_ready_o == 1'b1, "R6 accepted when ready", 64'(st_ready_o), 1);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        wait_cyc(2);
        check(wn == base + 1 && wa[base] == 32'h90, "R6 direct write", 64'(wa[base]), 64'h90);
        @(negedge clk);
        cwr_ready = 1'b0;
        st_valid = 1'b1;
        st_addr = 32'h83;
        st_data = 32'hBEEF;
        #1;
        check(st_ready_o == 1'b1, "R6 merge never stalls", 64'(st_ready_o), 1);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        load_chk(32'h83, 1'b1, 32'hBEEF, "R3 merged when full");
        cwr_ready = 1'b1;
        check(pf_n == pn, "R10 no prefetch for present or direct", 64'(pf_n - pn), 0);
        do_commit();
        wait_cyc(14);
        check(wn == base + 9, "R4 full flush count", 64'(wn - base), 9);
        check(wa[base+4] == 32'h83 && wd[base+4] == 32'hBEEF, "R3 merged word once", 64'(wd[base+4]), 64'hBEEF);

        // R7: eager immediate draining
        base = wn;
        dn = done_n;
        begin_tx(1'b1, 1'b0);
        do_store(32'h50, 32'h55);
        wait_cyc(3);
        check(wn == base + 1 && wa[base] == 32'h50, "R7 drained during tx", 64'(wn - base), 1);
        do_commit();
        wait_cyc(4);
        check(done_n == dn + 1, "R4 eager commit done", 64'(done_n - dn), 1);

        // R8: deferred draining at threshold 6 of 8
        base = wn;
        begin_tx(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) do_store(32'h60 + 32'(i), 32'h600 + 32'(i));
        wait_cyc(3);
        check(wn == base, "R8 held below threshold", 64'(wn - base), 0);
        do_store(32'h65, 32'h605);
        wait_cyc(4);
        check(wn == base + 1 && wa[base] == 32'h60, "R8 one drain at threshold", 64'(wn - base), 1);
        do_commit();
        wait_cyc(10);
        check(wn == base + 6 && wa[base+5] == 32'h65, "R8 R4 remaining flushed", 64'(wn - base), 6);

        // R12: store hits head while head is accepted
        base = wn;
        cwr_ready = 1'b0;
        begin_tx(1'b1, 1'b0);
        do_store(32'h40, 32'hD1);
        @(negedge clk);
        cwr_ready = 1'b1;
        st_valid = 1'b1;
        st_addr = 32'h40;
        st_data = 32'hD2;
        #1;
        check(st_ready_o == 1'b1, "R12 store accepted in collision", 64'(st_ready_o), 1);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        wait_cyc(3);
        check(wn == base + 2, "R12 two writes", 64'(wn - base), 2);
        check(wd[base] == 32'hD1 && wd[base+1] == 32'hD2, "R12 old then new", {wd[base], wd[base+1]}, {32'hD1, 32'hD2});
        do_commit();
        wait_cyc(4);

        // R9 R13: eager abort lingers; non-tx store stalls while not empty
        base = wn;
        dn = done_n;
        cwr_ready = 1'b0;
        begin_tx(1'b1, 1'b1);
        do_store(32'h70, 32'h700);
        do_store(32'h71, 32'h701);
        do_store(32'h72, 32'h702);
        do_abort();
        wait_cyc(2);
        check(wn == base, "R9 nothing yet", 64'(wn - base), 0);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = 32'hB0;
        st_data = 32'hB;
        #1;
        check(st_ready_o == 1'b0, "R13 non-tx store stalled", 64'(st_ready_o), 0);
        st_valid = 1'b0;
        cwr_ready = 1'b1;
        wait_cyc(6);
        check(wn == base + 3 && wa[base] == 32'h70 && wa[base+2] == 32'h72, "R9 pending written", 64'(wn - base), 3);
        check(done_n == dn, "R9 no done on eager abort", 64'(done_n - dn), 0);

        // R13: non-tx store with empty buffer goes direct
        base = wn;
        do_store(32'hA0, 32'hAA);
        wait_cyc(2);
        check(wn == base + 1 && wa[base] == 32'hA0, "R13 direct when idle", 64'(wn - base), 1);

        report();
        $finish;
    end
endmodule